// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a small CPU core. It gathers five request flags: two external lines, two timer overflows, and a serial port whose receive and transmit flags are merged into one source. Each source is gated by its own enable bit and by one global lock bit. Each source also carries a one-bit level, low or high. When the core reports an instruction boundary, the controller picks one eligible source and sends back an acknowledge pulse, a vector index and a 16-bit vector address.

Two in-service bits, one for each level, make nesting follow two-level rules. A low-level routine can be interrupted only by a high-level request. A high-level routine cannot be interrupted at all. A return pulse from the core ends the most recent level.

The enable and priority registers are eight bits wide. Software can write them as whole bytes or one bit at a time, and both can be read back at all times.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read 0x00, `irq_ack` and `irq_req` are 0, and `svc_lvl` is 2'b00.
- R2: A byte write loads the register, and a bit write changes only the bit selected by `bit_sel`. In the enable register, bit 6 is reserved. In the priority register, bits 7:6 are reserved. Reserved bits always read 0.
- R3: While enable bit 7 (global lock) is 0, no request is acknowledged and `irq_req` stays 0, whatever the source enable bits hold.
- R4: Each source has an enable bit and a priority bit at the same position: external 0 at bit 0, timer 0 at bit 1, external 1 at bit 2, timer 1 at bit 3, serial at bit 4. A source whose enable bit is 0 is never acknowledged.
- R5: Among eligible requests of the same level, the lowest bit position wins. The vector index is that bit position (0 to 4).
- R6: When requests of both levels are eligible, a high-level request (priority bit 1) is chosen first.
- R7: While a low-level routine is in service, another low-level request is not acknowledged, but a high-level request is. Each acknowledge sets the in-service bit of its level: `svc_lvl[0]` for low, `svc_lvl[1]` for high.
- R8: While the high in-service bit is set, no request is acknowledged and `irq_req` is 0.
- R9: A `reti` pulse clears `svc_lvl[1]` if it is set. Otherwise it clears `svc_lvl[0]`.
- R10: The serial source requests service when `ser_rx_flag` or `ser_tx_flag` is 1.
- R11: `irq_ack` rises for one cycle, in the cycle after a cycle in which `insn_boundary` was 1 and a request was eligible. It never rises without a boundary. `vec_idx` and `vec_addr` change only together with an acknowledge and hold their values otherwise.
- R12: `vec_addr` equals 8 × `vec_idx` + 3.
- R13: Bit 5 of each register can be written and read back, but it enables no source and changes no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_byte_we | input | 1 | Write `wdata` into the enable register |
| pri_byte_we | input | 1 | Write `wdata` into the priority register |
| wdata | input | 8 | Byte write data |
| en_bit_we | input | 1 | Write `bit_val` into enable bit `bit_sel` |
| pri_bit_we | input | 1 | Write `bit_val` into priority bit `bit_sel` |
| bit_sel | input | 3 | Bit position for bit writes |
| bit_val | input | 1 | Bit write value |
| en_q | output | 8 | Enable register readback |
| pri_q | output | 8 | Priority register readback |
| ext0_flag | input | 1 | External 0 request flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Registered: some request is eligible |
| irq_ack | output | 1 | Registered acknowledge strobe |
| vec_idx | output | 3 | Index of the acknowledged source |
| vec_addr | output | 16 | Vector address of the acknowledged source |
| svc_lvl | output | 2 | In-service bits {high, low} |

## Verification
A stuck or stale in-service bit has one of two visible effects. It blocks a later acknowledge that should happen, or it lets a same-level request through that should wait. Either one shows on `irq_ack` one cycle after the next boundary, and it also shows on `svc_lvl` right after the `reti` or acknowledge edge. A wrong pick by level or by polling order shows on `vec_idx` and `vec_addr` in the acknowledge cycle itself. The bench checks these against a queue of expected vectors, and it checks `svc_lvl` after every boundary and every return.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W      = 8;
  localparam int SRC_N      = 5;
  localparam int GLOBAL_BIT = 7;
  localparam logic [REG_W-1:0] EN_WMASK  = 8'hBF;
  localparam logic [REG_W-1:0] PRI_WMASK = 8'h3F;

  typedef enum logic [2:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int W = 8,
  parameter logic [W-1:0] EN_MASK  = '1,
  parameter logic [W-1:0] PRI_MASK = '1,
  localparam int SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_byte_we,
  input  logic             pri_byte_we,
  input  logic [W-1:0]     wdata,
  input  logic             en_bit_we,
  input  logic             pri_bit_we,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     pri_q
);
  localparam int NREG = 2;

  logic [NREG-1:0]        byte_we;
  logic [NREG-1:0]        bitw_we;
  logic [NREG-1:0][W-1:0] mask;
  logic [NREG-1:0][W-1:0] q;

  assign byte_we = {pri_byte_we, en_byte_we};
  assign bitw_we = {pri_bit_we, en_bit_we};
  assign mask    = {PRI_MASK, EN_MASK};

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[r] <= '0;
      end else if (byte_we[r]) begin
        q[r] <= wdata & mask[r];
      end else if (bitw_we[r]) begin
        q[r][bit_sel] <= bit_val & mask[r][bit_sel];
      end
    end
  end

  assign en_q  = q[0];
  assign pri_q = q[1];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     flags,
  input  logic [N-1:0]     en_src,
  input  logic             ea,
  input  logic [N-1:0]     pri_src,
  input  logic             svc_hi,
  input  logic             svc_lo,
  output logic             any_elig,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_hi
);
  logic [N-1:0] pending, hi_pend, lo_pend, elig;

  assign pending = flags & en_src & {N{ea}};
  assign hi_pend = pending & pri_src;
  assign lo_pend = pending & ~pri_src;

  always_comb begin
    if (svc_hi)       elig = '0;
    else if (svc_lo)  elig = hi_pend;
    else if (|hi_pend) elig = hi_pend;
    else              elig = lo_pend;
  end

  // polling order: lowest position wins
  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) pick_idx = IDX_W'(i);
    end
  end

  assign any_elig = |elig;
  assign pick_hi  = pri_src[pick_idx];
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst,
  input  logic ack_go,
  input  logic ack_hi,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);
  logic hi_n, lo_n;

  always_comb begin
    hi_n = svc_hi;
    lo_n = svc_lo;
    if (reti) begin
      if (svc_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (ack_go) begin
      if (ack_hi) hi_n = 1'b1;
      else        lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else begin
      svc_hi <= hi_n;
      svc_lo <= lo_n;
    end
  end

  p_hi_blocks_all_r8: assert property (@(posedge clk) disable iff (rst)
    svc_hi |-> !ack_go);
  p_lo_only_by_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (svc_lo && ack_go) |-> ack_hi);
  p_reti_hi_first_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && svc_hi) |=> (!svc_hi && svc_lo == $past(svc_lo)));
  p_reti_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && !svc_hi && !ack_go) |=> !svc_lo);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int W          = REG_W,
  parameter int N          = SRC_N,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W = $clog2(N),
  localparam int SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_byte_we,
  input  logic             pri_byte_we,
  input  logic [W-1:0]     wdata,
  input  logic             en_bit_we,
  input  logic             pri_bit_we,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     pri_q,
  input  logic             ext0_flag,
  input  logic             tmr0_flag,
  input  logic             ext1_flag,
  input  logic             tmr1_flag,
  input  logic             ser_rx_flag,
  input  logic             ser_tx_flag,
  input  logic             insn_boundary,
  input  logic             reti,
  output logic             irq_req,
  output logic             irq_ack,
  output logic [IDX_W-1:0] vec_idx,
  output logic [VEC_W-1:0] vec_addr,
  output logic [1:0]       svc_lvl
);
  logic [N-1:0]     flags;
  logic             any_elig, pick_hi, ack_go, svc_hi, svc_lo;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    flags = '0;
    flags[SRC_EXT0] = ext0_flag;
    flags[SRC_TMR0] = tmr0_flag;
    flags[SRC_EXT1] = ext1_flag;
    flags[SRC_TMR1] = tmr1_flag;
    flags[SRC_SER]  = ser_rx_flag | ser_tx_flag;
  end

  irq_regs #(.W(W), .EN_MASK(EN_WMASK), .PRI_MASK(PRI_WMASK)) u_regs (
    .clk(clk), .rst(rst),
    .en_byte_we(en_byte_we), .pri_byte_we(pri_byte_we), .wdata(wdata),
    .en_bit_we(en_bit_we), .pri_bit_we(pri_bit_we),
    .bit_sel(bit_sel), .bit_val(bit_val),
    .en_q(en_q), .pri_q(pri_q)
  );

  irq_arbiter #(.N(N)) u_arb (
    .flags(flags), .en_src(en_q[N-1:0]), .ea(en_q[GLOBAL_BIT]),
    .pri_src(pri_q[N-1:0]), .svc_hi(svc_hi), .svc_lo(svc_lo),
    .any_elig(any_elig), .pick_idx(pick_idx), .pick_hi(pick_hi)
  );

  assign ack_go = insn_boundary & any_elig;

  irq_svc_track u_svc (
    .clk(clk), .rst(rst), .ack_go(ack_go), .ack_hi(pick_hi), .reti(reti),
    .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_ack  <= 1'b0;
      vec_idx  <= '0;
      vec_addr <= '0;
    end else begin
      irq_req <= any_elig;
      irq_ack <= ack_go;
      if (ack_go) begin
        vec_idx  <= pick_idx;
        vec_addr <= VEC_W'(pick_idx) * VEC_W'(VEC_STRIDE) + VEC_W'(VEC_BASE);
      end
    end
  end

  assign svc_lvl = {svc_hi, svc_lo};

  p_ack_at_boundary_r11: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(insn_boundary));
  p_lock_gates_r3: assert property (@(posedge clk) disable iff (rst)
    (!en_q[GLOBAL_BIT] && insn_boundary) |=> !irq_ack);
  p_vec_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !irq_ack |-> $stable(vec_idx));
  p_vec_addr_r12: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (vec_addr == VEC_W'(vec_idx) * VEC_W'(VEC_STRIDE) + VEC_W'(VEC_BASE)));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_byte_we = 0, pri_byte_we = 0, en_bit_we = 0, pri_bit_we = 0, bit_val = 0;
  logic [7:0] wdata = '0;
  logic [2:0] bit_sel = '0;
  logic ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
  logic ser_rx_flag = 0, ser_tx_flag = 0, insn_boundary = 0, reti = 0;
  logic [7:0] en_q, pri_q;
  logic irq_req, irq_ack;
  logic [2:0] vec_idx;
  logic [15:0] vec_addr;
  logic [1:0] svc_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int exp_idx[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .en_byte_we(en_byte_we), .pri_byte_we(pri_byte_we),
    .wdata(wdata), .en_bit_we(en_bit_we), .pri_bit_we(pri_bit_we),
    .bit_sel(bit_sel), .bit_val(bit_val), .en_q(en_q), .pri_q(pri_q),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag),
    .tmr1_flag(tmr1_flag), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .insn_boundary(insn_boundary), .reti(reti), .irq_req(irq_req),
    .irq_ack(irq_ack), .vec_idx(vec_idx), .vec_addr(vec_addr), .svc_lvl(svc_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] d);
    en_byte_we = 1; wdata = d; step(); en_byte_we = 0;
  endtask

  task automatic wr_pri(input logic [7:0] d);
    pri_byte_we = 1; wdata = d; step(); pri_byte_we = 0;
  endtask

  task automatic bit_en(input logic [2:0] s, input logic v);
    en_bit_we = 1; bit_sel = s; bit_val = v; step(); en_bit_we = 0;
  endtask

  task automatic bit_pri(input logic [2:0] s, input logic v);
    pri_bit_we = 1; bit_sel = s; bit_val = v; step(); pri_bit_we = 0;
  endtask

  task automatic set_flags(input logic [4:0] f);
    {tmr1_flag, ext1_flag, tmr0_flag, ext0_flag} = f[3:0];
    ser_rx_flag = f[4];
    ser_tx_flag = 0;
  endtask

  task automatic boundary();
    insn_boundary = 1; step(); insn_boundary = 0;
  endtask

  task automatic expect_ack(input int idx, input string tag);
    exp_idx.push_back(idx);
    exp_tag.push_back(tag);
    boundary();
  endtask

  task automatic do_reti();
    reti = 1; step(); reti = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && irq_ack) begin
      if (exp_idx.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected ack actual=%0d expected=none", vec_idx);
      end else begin
        int e;
        string t;
        e = exp_idx.pop_front();
        t = exp_tag.pop_front();
        chk({t, " vec_idx"}, vec_idx, e);
        chk("R12 vec_addr", vec_addr, e * 8 + 3);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1
    chk("R1 en_q", en_q, 8'h00);
    chk("R1 pri_q", pri_q, 8'h00);
    chk("R1 irq_ack", irq_ack, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 svc_lvl", svc_lvl, 0);

    // R3: lock bit clear
    wr_en(8'h1F);
    set_flags(5'h1F);
    chk("R2 en byte", en_q, 8'h1F);
    boundary();
    chk("R3 no ack", irq_ack, 0);
    step();
    chk("R3 no req", irq_req, 0);

    // R2: reserved bits
    wr_en(8'hFF);
    chk("R2 en reserved", en_q, 8'hBF);
    wr_pri(8'hFF);
    chk("R2 pri reserved", pri_q, 8'h3F);
    wr_pri(8'h00);
    step();
    chk("R11 req without boundary", irq_req, 1);
    chk("R11 no ack without boundary", irq_ack, 0);

    // R5 polling order, R7 low blocks low, R9
    expect_ack(0, "R5");
    chk("R7 svc low", svc_lvl, 2'b01);
    ext0_flag = 0;
    boundary();
    chk("R7 low blocks low", irq_ack, 0);
    do_reti();
    chk("R9 reti low", svc_lvl, 2'b00);
    expect_ack(1, "R5");
    do_reti();

    // R4 per-source enables
    set_flags(5'h1F);
    wr_en(8'h84);
    expect_ack(2, "R4");
    do_reti();
    wr_en(8'h88);
    expect_ack(3, "R4");
    do_reti();
    wr_en(8'h81);
    expect_ack(0, "R4");
    do_reti();

    // R10 serial merge
    wr_en(8'h90);
    set_flags(5'h10);
    expect_ack(4, "R10 rx");
    do_reti();
    ser_rx_flag = 0; ser_tx_flag = 1;
    expect_ack(4, "R10 tx");
    do_reti();
    ser_tx_flag = 0;
    boundary();
    chk("R10 no serial flag", irq_ack, 0);
    step();
    chk("R10 no req", irq_req, 0);

    // R6 high first, R8 high blocks all
    wr_en(8'h9F);
    wr_pri(8'h08);
    set_flags(5'h1F);
    expect_ack(3, "R6");
    chk("R7 svc high", svc_lvl, 2'b10);
    boundary();
    chk("R8 no ack", irq_ack, 0);
    chk("R8 no req", irq_req, 0);
    do_reti();
    chk("R9 reti high", svc_lvl, 2'b00);

    // nesting
    set_flags(5'h01);
    expect_ack(0, "R7 low");
    chk("R7 svc", svc_lvl, 2'b01);
    tmr1_flag = 1;
    expect_ack(3, "R7 preempt");
    chk("R7 nested svc", svc_lvl, 2'b11);
    boundary();
    chk("R8 nested no ack", irq_ack, 0);
    do_reti();
    chk("R9 high cleared first", svc_lvl, 2'b01);
    do_reti();
    chk("R9 low cleared", svc_lvl, 2'b00);

    // R11 pulse and hold
    set_flags(5'h08);
    expect_ack(3, "R11");
    step();
    chk("R11 single pulse", irq_ack, 0);
    set_flags(5'h01);
    step(); step();
    chk("R11 idx hold", vec_idx, 3);
    chk("R11 addr hold", vec_addr, 27);
    do_reti();

    // R13 bit 5 inert; R2 bit access
    wr_pri(8'h00);
    wr_en(8'h80);
    bit_en(3'd5, 1'b1);
    chk("R2 en bit set", en_q, 8'hA0);
    bit_pri(3'd5, 1'b1);
    chk("R2 pri bit set", pri_q, 8'h20);
    set_flags(5'h1F);
    boundary();
    chk("R13 no ack", irq_ack, 0);
    step();
    chk("R13 no req", irq_req, 0);
    bit_en(3'd5, 1'b0);
    chk("R2 en bit clear", en_q, 8'h80);
    bit_en(3'd6, 1'b1);
    chk("R2 reserved bit write", en_q, 8'h80);

    step(); step();
    chk("scoreboard drained", exp_idx.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule